// File: doc/BRIEF.md
# Multi-Channel Reloading Down-Count Timer

This block is a register-mapped timer with three independent 32-bit down-counting channels. Each channel holds a reload value, a live count and a small control word that picks its count rate and enables its interrupt. A single shared start register carries one run bit per channel, so software starts and stops any mix of channels with one write.

A running channel takes one step down on each tick of its selected clock divider. When the count steps past zero it reloads from its reload register and keeps running. On that step it also sets a sticky underflow flag. The channel's interrupt line is high while the flag and the interrupt enable are both set. Software reads and writes everything through a plain synchronous port that uses byte offsets. Read data is combinational from the addressed register.

Top module: `rldtmr_top`

## Requirements
- R1: Register map by byte offset. Offset 0 is the start register. Channel n owns offsets 4+12n (reload), 8+12n (count) and 12+12n (control). Any other offset reads 0, and a write to it changes no register.
- R2: The start register is 8 bits wide and read/write. Bit n set runs channel n. Bit n clear freezes channel n's count. Channels are independent of each other.
- R3: A running channel decrements by one on each selected tick. On a tick with a count of 0 it loads the reload value and continues.
- R4: Control bits [2:0] select the tick rate: 0 is every 4 clocks, 1 is every 16, 2 is every 64, 3 is every 256, 4 is every 1024. Codes 5 to 7 behave as code 0. The dividers count freely from reset, so with a reload value of 1 the interrupt recurs every 2×N clocks.
- R5: Control bit 8 is the underflow flag. It is set on the underflow tick and stays set. A control write with bit 8 at 0 clears it, and a write with bit 8 at 1 leaves it as it was.
- R6: Control bit 5 enables the interrupt. Channel n's irq bit is high exactly while its flag and its enable are both 1.
- R7: If a control write clears the flag on the same clock as an underflow, the flag ends up set.
- R8: After reset all start bits are 0, reload and count registers are all-ones, and control registers are 0. The internal reset is released on the second clock edge after rst_n rises.
- R9: A write to a count register loads the written value. This write takes priority over a tick on the same clock.
- R10: A control register reads back only bits 8, 5 and [2:0]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not reading) |
| irq | output | 3 | Per-channel interrupt request |

## Verification
A behavioural model in the bench tracks every register and is compared with the irq lines and a counter read on every clock. Channels run with different reload values and run masks, which separates independent run control from shared state. The interrupt period is measured at all eight rate codes with a reload of 1, which shows any wrong divider or off-by-one reload. A clear write is aimed at the exact underflow clock to check that the set wins. Writes of 0 and 1 to the flag bit, with the interrupt enable both on and off, separate the sticky, clear and gating behaviour.

// File: rtl/rldtmr_pkg.sv
package rldtmr_pkg;
  localparam int CNT_W      = 32;
  localparam int CTRL_W     = 16;
  localparam int START_W    = 8;
  localparam int PSC_W      = 3;
  localparam int NDIV       = 5;
  localparam int DIV_EXP0   = 2;
  localparam int DIV_STEP   = 2;
  localparam int FLAG_POS   = 8;
  localparam int IE_POS     = 5;
  localparam int BLK_BASE   = 4;
  localparam int BLK_STRIDE = 12;
  localparam int OFF_RELOAD = 0;
  localparam int OFF_COUNT  = 4;
  localparam int OFF_CTRL   = 8;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic [PSC_W-1:0] rate;
  } ctl_t;

  function automatic logic [CTRL_W-1:0] ctl_pack(ctl_t c);
    logic [CTRL_W-1:0] w;
    w              = '0;
    w[FLAG_POS]    = c.flag;
    w[IE_POS]      = c.ie;
    w[PSC_W-1:0]   = c.rate;
    return w;
  endfunction
endpackage

// File: rtl/rldtmr_rstsync.sv
module rldtmr_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/rldtmr_prediv.sv
module rldtmr_prediv #(
  parameter int NDIV     = 5,
  parameter int DIV_EXP0 = 2,
  parameter int DIV_STEP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NDIV-1:0] tick
);
  localparam int PW = DIV_EXP0 + DIV_STEP * (NDIV - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;

  always_comb pre_d = pre_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // divider i ticks when its low bits are all ones: once every 2^(EXP0+STEP*i) clocks
  for (genvar i = 0; i < NDIV; i++) begin : g_tap
    localparam int E = DIV_EXP0 + DIV_STEP * i;
    assign tick[i] = &pre_q[E-1:0];
  end

  // R4: a slower divider only ticks on a clock where every faster one ticks
  for (genvar i = 1; i < NDIV; i++) begin : g_nest
    a_r4_tick_nested: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] |-> tick[i-1]);
  end
endmodule

// File: rtl/rldtmr_chan.sv
module rldtmr_chan
  import rldtmr_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int ND = NDIV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [ND-1:0] tick,
  input  logic          wr_reload,
  input  logic          wr_count,
  input  logic          wr_ctrl,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  reload_q,
  output logic [W-1:0]  count_q,
  output ctl_t          ctl_q,
  output logic          irq
);
  logic [W-1:0] reload_d, count_d;
  ctl_t         ctl_d;
  logic         sel_tick, step, at_zero, uf;
  logic         count_en;

  // rate select; codes beyond the implemented dividers fall back to the fastest
  always_comb begin
    sel_tick = tick[0];
    for (int i = 0; i < ND; i++) begin
      if (ctl_q.rate == PSC_W'(i)) sel_tick = tick[i];
    end
  end

  always_comb begin
    step     = run & sel_tick;
    at_zero  = (count_q == '0);
    uf       = step & at_zero;
    count_en = wr_count | step;
    reload_d = wr_reload ? wdata : reload_q;
    if (wr_count)     count_d = wdata;
    else if (at_zero) count_d = reload_q;
    else              count_d = count_q - W'(1);
    ctl_d      = ctl_q;
    if (wr_ctrl) begin
      ctl_d.rate = wdata[PSC_W-1:0];
      ctl_d.ie   = wdata[IE_POS];
      ctl_d.flag = ctl_q.flag & wdata[FLAG_POS];
    end
    if (uf) ctl_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '1;
    else if (wr_reload) reload_q <= reload_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '1;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign irq = ctl_q.flag & ctl_q.ie;

  // R3: stepping past zero brings in the old reload value
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && !wr_count) |=> (count_q == $past(reload_q)));
  // R2: a stopped channel without a count write keeps its value
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_count) |=> $stable(count_q));
  // R5: flag rises only through an underflow
  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.flag && !uf) |=> !ctl_q.flag);
  // R7: an underflow always leaves the flag set, whatever the bus does
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> ctl_q.flag);
endmodule

// File: rtl/rldtmr_top.sv
module rldtmr_top
  import rldtmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 8,
  parameter int DW  = CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);
  // NCH must not exceed START_W: one start bit per channel
  logic rst_n_i;

  rldtmr_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  logic [NDIV-1:0] tick;

  rldtmr_prediv #(.NDIV(NDIV), .DIV_EXP0(DIV_EXP0), .DIV_STEP(DIV_STEP)) u_div (
    .clk   (clk),
    .rst_n (rst_n_i),
    .tick  (tick)
  );

  logic               wr_any, rd_any;
  logic               hit_start;
  logic [START_W-1:0] start_q, start_d;

  always_comb begin
    wr_any    = bus_sel & bus_wr;
    rd_any    = bus_sel & ~bus_wr;
    hit_start = wr_any & (bus_addr == AW'(0));
    start_d   = bus_wdata[START_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)       start_q <= '0;
    else if (hit_start) start_q <= start_d;
  end

  a_r2_start_by_write_only: assert property (@(posedge clk) disable iff (!rst_n_i)
    !hit_start |=> $stable(start_q));

  logic [DW-1:0] reload_w [NCH];
  logic [DW-1:0] count_w  [NCH];
  ctl_t          ctl_w    [NCH];
  logic [NCH-1:0] wr_ctrl_v;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int BASE = BLK_BASE + BLK_STRIDE * g;
    logic wr_rl, wr_ct, wr_cr;

    always_comb begin
      wr_rl = wr_any & (bus_addr == AW'(BASE + OFF_RELOAD));
      wr_ct = wr_any & (bus_addr == AW'(BASE + OFF_COUNT));
      wr_cr = wr_any & (bus_addr == AW'(BASE + OFF_CTRL));
    end
    assign wr_ctrl_v[g] = wr_cr;

    rldtmr_chan #(.W(DW), .ND(NDIV)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .run       (start_q[g]),
      .tick      (tick),
      .wr_reload (wr_rl),
      .wr_count  (wr_ct),
      .wr_ctrl   (wr_cr),
      .wdata     (bus_wdata),
      .reload_q  (reload_w[g]),
      .count_q   (count_w[g]),
      .ctl_q     (ctl_w[g]),
      .irq       (irq[g])
    );

    // R6: a raised interrupt stays up until software touches that control word
    a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n_i)
      (irq[g] && !wr_cr) |=> irq[g]);
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      if (bus_addr == AW'(0)) bus_rdata = DW'(start_q);
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == AW'(BLK_BASE + BLK_STRIDE * n + OFF_RELOAD)) bus_rdata = reload_w[n];
        if (bus_addr == AW'(BLK_BASE + BLK_STRIDE * n + OFF_COUNT))  bus_rdata = count_w[n];
        if (bus_addr == AW'(BLK_BASE + BLK_STRIDE * n + OFF_CTRL))   bus_rdata = DW'(ctl_pack(ctl_w[n]));
      end
    end
  end

  // R1: reads of unmapped offsets return zero
  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_any && bus_addr > AW'(BLK_BASE + BLK_STRIDE * NCH - 4)) |-> (bus_rdata == '0));
endmodule

// File: tb/rldtmr_top_tb_top.sv
module rldtmr_top_tb_top;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel, wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [2:0]  irq;

  always #2 clk = ~clk;

  rldtmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  int     n_chk = 0, n_bad = 0, rot = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  // ---------------- behavioural reference ----------------
  logic [31:0] m_rl [NCH];
  logic [31:0] m_cnt[NCH];
  logic [2:0]  m_psc[NCH];
  logic        m_ie [NCH];
  logic        m_flg[NCH];
  logic [7:0]  m_start;
  int          m_pre, m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) begin
        m_rl[n] = '1; m_cnt[n] = '1; m_psc[n] = 0; m_ie[n] = 0; m_flg[n] = 0;
      end
      m_start = 0; m_pre = 0; m_hold = 0;
    end else if (m_hold < 2) begin
      m_hold++;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        automatic int base = 4 + 12 * n;
        automatic int dv = (m_psc[n] <= 3'd4) ? (4 << (2 * int'(m_psc[n]))) : 4;
        automatic bit tk = m_start[n] && ((m_pre % dv) == dv - 1);
        automatic bit uf = tk && (m_cnt[n] == 0);
        automatic logic [31:0] old_rl = m_rl[n];
        if (sel && wr && addr == 8'(base)) m_rl[n] = wdata;
        if (sel && wr && addr == 8'(base + 4)) m_cnt[n] = wdata;
        else if (tk) m_cnt[n] = uf ? old_rl : m_cnt[n] - 1;
        if (sel && wr && addr == 8'(base + 8)) begin
          m_psc[n] = wdata[2:0]; m_ie[n] = wdata[5];
          if (!wdata[8]) m_flg[n] = 0;
        end
        if (uf) m_flg[n] = 1;
      end
      if (sel && wr && addr == 8'h00) m_start = wdata[7:0];
      m_pre++;
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h00) return {24'h0, m_start};
    for (int n = 0; n < NCH; n++) begin
      if (a == 8'(4 + 12 * n))  return m_rl[n];
      if (a == 8'(8 + 12 * n))  return m_cnt[n];
      if (a == 8'(12 + 12 * n)) return {23'h0, m_flg[n], 2'b0, m_ie[n], 2'b0, m_psc[n]};
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a == 0) return "R2";
    if (a > 8'd36 || a[1:0] != 0) return "R1";
    case ((a - 4) % 12)
      0: return "R1";
      4: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    logic [NCH-1:0] ei;
    if (rst_n) begin
      for (int n = 0; n < NCH; n++) ei[n] = m_flg[n] & m_ie[n];
      check("R6", "irq vs model", 32'(irq), 32'(ei));
      if (sel && !wr) check(tag_of(addr), "read vs model", rdata, m_read(addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int k);
    repeat (k) begin
      @(posedge clk); #1;
      sel = 1; wr = 0; addr = 8'(8 + 12 * (rot % 3)); rot++;
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    sel = 1; wr = 1; addr = a; wdata = d;
  endtask

  task automatic rd_get(logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic rd_chk(logic [7:0] a, string tag, logic [31:0] exp);
    logic [31:0] v;
    rd_get(a, v);
    check(tag, $sformatf("read @%0h", a), v, exp);
  endtask

  task automatic wait_irq(int n, output longint t);
    t = -1;
    for (int k = 0; k < 5000; k++) begin
      idle(1);
      @(negedge clk);
      if (irq[n]) begin t = cyc; break; end
    end
  endtask

  task automatic irq_chk(int n, logic exp, string tag);
    idle(1);
    @(negedge clk);
    check(tag, $sformatf("irq[%0d]", n), 32'(irq[n]), 32'(exp));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog: actual=hung expected=complete");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] v0, v1;
    longint t1, t2;
    sel = 0; wr = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(3);

    // R8 reset values
    rd_chk(8'h00, "R8", 32'h0);
    rd_chk(8'h04, "R8", 32'hFFFF_FFFF);
    rd_chk(8'h08, "R8", 32'hFFFF_FFFF);
    rd_chk(8'h0C, "R8", 32'h0);
    rd_chk(8'h24, "R8", 32'h0);
    irq_chk(0, 1'b0, "R8");

    // R1 map and unmapped offsets
    wr_reg(8'h40, 32'h1234_5678);
    rd_chk(8'h40, "R1", 32'h0);
    rd_chk(8'h02, "R1", 32'h0);
    wr_reg(8'h1C, 32'hA5A5_0000);
    rd_chk(8'h1C, "R1", 32'hA5A5_0000);
    rd_chk(8'h10, "R1", 32'hFFFF_FFFF);

    // R10 control readback mask
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    rd_chk(8'h0C, "R10", 32'h0000_0027);
    wr_reg(8'h0C, 32'h0);

    // R9 direct count load
    wr_reg(8'h08, 32'h0000_0100);
    rd_chk(8'h08, "R9", 32'h0000_0100);

    // R2 independent run bits, freeze on stop
    wr_reg(8'h00, 32'h2);
    idle(200);
    rd_chk(8'h08, "R2", 32'h0000_0100);
    rd_chk(8'h20, "R2", 32'hFFFF_FFFF);
    rd_get(8'h14, v0);
    check("R2", "ch1 moving", 32'(v0 != 32'hFFFF_FFFF), 32'h1);
    rd_chk(8'h00, "R2", 32'h2);
    wr_reg(8'h00, 32'h0);
    idle(1);
    rd_get(8'h14, v0);
    idle(60);
    rd_get(8'h14, v1);
    check("R2", "ch1 frozen", v1, v0);

    // R3 reload sequence on ch0, compared every clock by the model
    wr_reg(8'h04, 32'h3);
    wr_reg(8'h08, 32'h0);
    wr_reg(8'h00, 32'h1);
    idle(45);
    wr_reg(8'h00, 32'h0);
    rd_chk(8'h0C, "R3", 32'h100);
    rd_get(8'h08, v0);
    check("R3", "count within reload range", 32'(v0 <= 32'h3), 32'h1);

    // R4 interrupt period at every rate code, reload value 1
    for (int p = 0; p < 8; p++) begin
      automatic int dv = (p <= 4) ? (4 << (2 * p)) : 4;
      wr_reg(8'h00, 32'h0);
      wr_reg(8'h0C, 32'h20 | p);
      wr_reg(8'h04, 32'h1);
      wr_reg(8'h08, 32'h1);
      wr_reg(8'h00, 32'h1);
      wait_irq(0, t1);
      wr_reg(8'h0C, 32'h20 | p);
      wait_irq(0, t2);
      check("R4", $sformatf("period code %0d", p), 32'(t2 - t1), 32'(2 * dv));
    end
    wr_reg(8'h00, 32'h0);
    wr_reg(8'h0C, 32'h0);

    // R7 clear aimed at the underflow clock of ch1
    wr_reg(8'h18, 32'h0);
    wr_reg(8'h10, 32'h5);
    wr_reg(8'h14, 32'h0);
    wr_reg(8'h00, 32'h2);
    for (int k = 0; k < 64; k++) begin
      @(posedge clk); #1;
      if (m_start[1] && (m_pre % 4) == 3 && m_cnt[1] == 0) begin
        sel = 1; wr = 1; addr = 8'h18; wdata = 32'h0;
        break;
      end
      sel = 1; wr = 0; addr = 8'h14;
    end
    wr_reg(8'h00, 32'h0);
    rd_chk(8'h18, "R7", 32'h100);

    // R5 sticky flag: writing 1 keeps, writing 0 clears, writing 1 cannot set
    wr_reg(8'h18, 32'h100);
    rd_chk(8'h18, "R5", 32'h100);
    wr_reg(8'h18, 32'h0);
    rd_chk(8'h18, "R5", 32'h0);
    wr_reg(8'h18, 32'h100);
    rd_chk(8'h18, "R5", 32'h0);

    // R6 interrupt gating on ch2
    wr_reg(8'h24, 32'h20);
    wr_reg(8'h1C, 32'h2);
    wr_reg(8'h20, 32'h0);
    wr_reg(8'h00, 32'h4);
    wait_irq(2, t1);
    check("R6", "irq2 raised", 32'(t1 >= 0), 32'h1);
    wr_reg(8'h00, 32'h0);
    irq_chk(2, 1'b1, "R6");
    wr_reg(8'h24, 32'h20);
    irq_chk(2, 1'b0, "R6");
    wr_reg(8'h24, 32'h0);
    wr_reg(8'h20, 32'h0);
    wr_reg(8'h00, 32'h4);
    idle(12);
    wr_reg(8'h00, 32'h0);
    rd_chk(8'h24, "R6", 32'h100);
    irq_chk(2, 1'b0, "R6");
    wr_reg(8'h24, 32'h120);
    irq_chk(2, 1'b1, "R6");

    idle(4);
    finish_run();
  end
endmodule